// File: doc/BRIEF.md
# CAN Acceptance Filter Bank Array

This block decides whether a received CAN frame identifier is kept. It also says which filter kept it. The identifier is a left-aligned 32-bit word, and the frame's identifier bits sit at the top. The block holds `NUM_BANKS` filter banks, and each bank has eight byte registers. A per-bank control byte does three things: it switches the bank on or off, sets its scale (one 32-bit, two 16-bit or four 8-bit filters), and sets the list-or-mask mode of its lower and upper register halves separately.

A receive path presents an identifier with a one-cycle strobe. One clock later the block returns an accept flag and a filter number. The receive path stores that number with the message, and software can use it as a direct table index. When several filters hit, a fixed ranking chooses the number. List-mode filters come first, then wider filters, then the lowest number.

The byte registers are loaded through a byte write port. A bank has to be switched off before its bytes can be changed.

Top module: `can_filter_bank_array`

## Requirements
- R1: After reset, every bank is inactive with scale 0, both mode bits 0 and all bytes 0. `match_valid`, `match_accept` and `match_index` are 0.
- R2: Address layout: address bit 5 selects a bank's control byte, bits 4:3 are the bank, and bits 2:0 are the byte register. A byte-register write to a bank that is active is ignored. The same write to an inactive bank takes effect at that clock edge.
- R3: An inactive bank never produces a hit.
- R4: Control byte layout: bit 0 = active, bits 2:1 = scale, bit 3 = low-half mode, bit 4 = high-half mode. Scale 00 gives four 8-bit filters on byte pairs (0,1), (2,3), (4,5) and (6,7). Each compares identifier bits 31:24. Scale 01 gives two 16-bit filters: words {1,0}/{3,2} and {5,4}/{7,6}. Each compares bits 31:16. Scale 10 or 11 gives one 32-bit filter: words {3,2,1,0}/{7,6,5,4}. In every word, the higher byte number is more significant.
- R5: A mode bit of 1 selects list mode and 0 selects mask mode. In 16-bit scale the low-half bit governs the filter ending in registers 2,3 and the high-half bit governs the one ending in 6,7. In 8-bit scale the low-half bit governs the filters ending in registers 1 and 3, and the high-half bit governs those ending in 5 and 7.
- R6: In 32-bit scale, a bank whose two mode bits differ never hits.
- R7: In mask mode, the first word is an identifier and the second is a care mask. The filter hits when the key equals the identifier on every bit where the mask is 1.
- R8: In list mode, each of the two words is an identifier that hits only on an exact key match.
- R9: Among hits, a list-mode filter is reported in preference to any mask-mode filter.
- R10: Among hits of the same mode, a wider filter (32 over 16 over 8 bits) is reported in preference to a narrower one.
- R11: Among hits of the same mode and width, the lowest filter number is reported.
- R12: Filter numbers run from 0 in bank order and then register order. This counts every bank, active or not. A mask filter takes one number and a list filter takes two, first word first. A mismatched 32-bit bank takes one.
- R13: A strobe on `id_valid` gives `match_valid` high exactly one cycle later, together with the accept flag and the number. On a reject, or in a cycle without a result, `match_accept` and `match_index` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W = BANK_W+4 | Write address (control or byte register) |
| cfg_wdata | input | 8 | Write data |
| id_valid | input | 1 | Identifier strobe |
| id_in | input | 32 | Left-aligned frame identifier |
| match_valid | output | 1 | Result valid, one cycle after strobe |
| match_accept | output | 1 | At least one active filter hit |
| match_index | output | IDX_W = clog2(8*NUM_BANKS) | Number of the selected filter |

## Verification
The assertions assume that `rst_n` is held low long enough for the first edge to clear all state. They also assume that `cfg_addr` names a bank below `NUM_BANKS`, so every write lands in a real bank. The stimulus only issues addresses inside that range. It drives every input at the falling edge, so the configuration seen at a strobe edge is always the pre-write one. The random phase also writes bytes to active banks on purpose, so the lock-out rule is exercised under load and not only in the directed case.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

  localparam logic [1:0] SCALE_8  = 2'b00;
  localparam logic [1:0] SCALE_16 = 2'b01;

  localparam logic [1:0] COV_8  = 2'd0;
  localparam logic [1:0] COV_16 = 2'd1;
  localparam logic [1:0] COV_32 = 2'd2;

  typedef struct packed {
    logic       mode_hi;
    logic       mode_lo;
    logic [1:0] scale;
    logic       active;
  } bank_cfg_t;

  // Numbers consumed by one bank: one per mask filter, two per list filter.
  function automatic int unsigned bank_filter_count(bank_cfg_t c);
    int unsigned lo_n, hi_n;
    lo_n = c.mode_lo ? 2 : 1;
    hi_n = c.mode_hi ? 2 : 1;
    case (c.scale)
      SCALE_8:  return 2 * lo_n + 2 * hi_n;
      SCALE_16: return lo_n + hi_n;
      default:  return (c.mode_lo && c.mode_hi) ? 2 : 1;
    endcase
  endfunction

  function automatic logic masked_hit(logic [31:0] key, logic [31:0] idv,
                                      logic [31:0] msk);
    return ((key ^ idv) & msk) == 32'd0;
  endfunction

  // Ranking key: list mode dominates, then coverage.
  function automatic logic [2:0] rank_of(logic is_list, logic [1:0] cov);
    return {is_list, cov};
  endfunction

endpackage

// File: rtl/cfb_cfg_regs.sv
module cfb_cfg_regs
  import can_filt_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [7:0]               cfg_wdata,
  output bank_cfg_t [NB-1:0]       cfg_o,
  output logic [NB-1:0][7:0][7:0]  bytes_o
);

  logic              ctl_sel;
  logic [BANK_W-1:0] bank_sel;
  logic [2:0]        reg_sel;

  assign ctl_sel  = cfg_addr[ADDR_W-1];
  assign bank_sel = cfg_addr[BANK_W+2:3];
  assign reg_sel  = cfg_addr[2:0];

  logic [NB-1:0] ctl_wr;
  logic [NB-1:0] byte_wr_hit;
  logic [NB-1:0] byte_wr_blocked;
  logic [NB-1:0] byte_wr_ok;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign ctl_wr[b]          = cfg_we &&  ctl_sel && (bank_sel == BANK_W'(b));
    assign byte_wr_hit[b]     = cfg_we && !ctl_sel && (bank_sel == BANK_W'(b));
    assign byte_wr_blocked[b] = byte_wr_hit[b] &&  cfg_o[b].active;
    assign byte_wr_ok[b]      = byte_wr_hit[b] && !cfg_o[b].active;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_o[b]   <= '0;
        bytes_o[b] <= '0;
      end else begin
        if (ctl_wr[b]) begin
          cfg_o[b].active  <= cfg_wdata[0];
          cfg_o[b].scale   <= cfg_wdata[2:1];
          cfg_o[b].mode_lo <= cfg_wdata[3];
          cfg_o[b].mode_hi <= cfg_wdata[4];
        end
        if (byte_wr_ok[b]) begin
          bytes_o[b][reg_sel] <= cfg_wdata;
        end
      end
    end

    // R2: an active bank's bytes do not move under a write.
    a_r2_locked_bytes: assert property (@(posedge clk) disable iff (!rst_n)
      byte_wr_blocked[b] |=> $stable(bytes_o[b]))
      else $error("a_r2_locked_bytes bank %0d", b);

    // R2: a write to an inactive bank lands in the addressed byte.
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      byte_wr_ok[b] |=> bytes_o[b][$past(reg_sel)] == $past(cfg_wdata))
      else $error("a_r2_write_lands bank %0d", b);
  end

endmodule

// File: rtl/cfb_bank_match.sv
module cfb_bank_match
  import can_filt_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  bank_cfg_t               cfg_i,
  input  logic [7:0][7:0]         bytes_i,
  input  logic [31:0]             id_i,
  input  logic [IDX_W-1:0]        base_i,
  output logic [7:0]              hits_o,
  output logic [7:0][2:0]         rank_o,
  output logic [7:0][IDX_W-1:0]   idx_o
);

  logic [7:0]  hit_raw;
  logic [31:0] key8, key16;

  assign key8  = {24'd0, id_i[31:24]};
  assign key16 = {16'd0, id_i[31:16]};

  always_comb begin
    logic        lst;
    logic [31:0] wa, wb;
    int unsigned n;
    hit_raw = '0;
    rank_o  = '0;
    idx_o   = '0;
    n       = 0;
    case (cfg_i.scale)
      SCALE_8: begin
        for (int f = 0; f < 4; f++) begin
          lst = (f < 2) ? cfg_i.mode_lo : cfg_i.mode_hi;
          wa  = {24'd0, bytes_i[2*f]};
          wb  = {24'd0, bytes_i[2*f+1]};
          if (lst) begin
            hit_raw[2*f]   = (key8 == wa);
            rank_o[2*f]    = rank_of(1'b1, COV_8);
            idx_o[2*f]     = base_i + IDX_W'(n);
            hit_raw[2*f+1] = (key8 == wb);
            rank_o[2*f+1]  = rank_of(1'b1, COV_8);
            idx_o[2*f+1]   = base_i + IDX_W'(n + 1);
            n              = n + 2;
          end else begin
            hit_raw[2*f] = masked_hit(key8, wa, wb);
            rank_o[2*f]  = rank_of(1'b0, COV_8);
            idx_o[2*f]   = base_i + IDX_W'(n);
            n            = n + 1;
          end
        end
      end
      SCALE_16: begin
        for (int f = 0; f < 2; f++) begin
          lst = (f == 0) ? cfg_i.mode_lo : cfg_i.mode_hi;
          wa  = {16'd0, bytes_i[4*f+1], bytes_i[4*f]};
          wb  = {16'd0, bytes_i[4*f+3], bytes_i[4*f+2]};
          if (lst) begin
            hit_raw[4*f]   = (key16 == wa);
            rank_o[4*f]    = rank_of(1'b1, COV_16);
            idx_o[4*f]     = base_i + IDX_W'(n);
            hit_raw[4*f+2] = (key16 == wb);
            rank_o[4*f+2]  = rank_of(1'b1, COV_16);
            idx_o[4*f+2]   = base_i + IDX_W'(n + 1);
            n              = n + 2;
          end else begin
            hit_raw[4*f] = masked_hit(key16, wa, wb);
            rank_o[4*f]  = rank_of(1'b0, COV_16);
            idx_o[4*f]   = base_i + IDX_W'(n);
            n            = n + 1;
          end
        end
      end
      default: begin
        lst = cfg_i.mode_lo;
        wa  = {bytes_i[3], bytes_i[2], bytes_i[1], bytes_i[0]};
        wb  = {bytes_i[7], bytes_i[6], bytes_i[5], bytes_i[4]};
        if (cfg_i.mode_lo != cfg_i.mode_hi) begin
          hit_raw = '0;
        end else if (lst) begin
          hit_raw[0] = (id_i == wa);
          rank_o[0]  = rank_of(1'b1, COV_32);
          idx_o[0]   = base_i;
          hit_raw[4] = (id_i == wb);
          rank_o[4]  = rank_of(1'b1, COV_32);
          idx_o[4]   = base_i + IDX_W'(1);
        end else begin
          hit_raw[0] = masked_hit(id_i, wa, wb);
          rank_o[0]  = rank_of(1'b0, COV_32);
          idx_o[0]   = base_i;
        end
      end
    endcase
  end

  assign hits_o = hit_raw & {8{cfg_i.active}};

endmodule

// File: rtl/cfb_priority_pick.sv
module cfb_priority_pick #(
  parameter int NB    = 4,
  parameter int IDX_W = 5
) (
  input  logic [NB-1:0][7:0]              hits_i,
  input  logic [NB-1:0][7:0][2:0]         rank_i,
  input  logic [NB-1:0][7:0][IDX_W-1:0]   idx_i,
  output logic                            any_o,
  output logic [IDX_W-1:0]                idx_o
);

  logic [2:0] best_rank;

  // Scan in number order; only a strictly better rank replaces the holder,
  // so ties resolve to the lowest number.
  always_comb begin
    any_o     = 1'b0;
    best_rank = '0;
    idx_o     = '0;
    for (int b = 0; b < NB; b++) begin
      for (int s = 0; s < 8; s++) begin
        if (hits_i[b][s] && (!any_o || rank_i[b][s] > best_rank)) begin
          any_o     = 1'b1;
          best_rank = rank_i[b][s];
          idx_o     = idx_i[b][s];
        end
      end
    end
  end

endmodule

// File: rtl/can_filter_bank_array.sv
module can_filter_bank_array
  import can_filt_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W    = BANK_W + 4,
  localparam int IDX_W     = $clog2(8 * NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              id_valid,
  input  logic [31:0]       id_in,
  output logic              match_valid,
  output logic              match_accept,
  output logic [IDX_W-1:0]  match_index
);

  localparam int CNT_W = $clog2(8 * NUM_BANKS + 1);

  bank_cfg_t [NUM_BANKS-1:0]              bank_cfg;
  logic [NUM_BANKS-1:0][7:0][7:0]         bank_bytes;
  logic [NUM_BANKS:0][CNT_W-1:0]          base_acc;
  logic [NUM_BANKS-1:0][7:0]              bank_hits;
  logic [NUM_BANKS-1:0][7:0][2:0]         bank_rank;
  logic [NUM_BANKS-1:0][7:0][IDX_W-1:0]   bank_idx;
  logic                                   pick_any;
  logic [IDX_W-1:0]                       pick_idx;
  logic [CNT_W-1:0]                       total_cnt;

  cfb_cfg_regs #(
    .NB(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_o    (bank_cfg),
    .bytes_o  (bank_bytes)
  );

  // Running first number of each bank.
  always_comb begin
    base_acc[0] = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      base_acc[b+1] = base_acc[b] + CNT_W'(bank_filter_count(bank_cfg[b]));
    end
  end
  assign total_cnt = base_acc[NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    cfb_bank_match #(.IDX_W(IDX_W)) u_match (
      .cfg_i  (bank_cfg[b]),
      .bytes_i(bank_bytes[b]),
      .id_i   (id_in),
      .base_i (base_acc[b][IDX_W-1:0]),
      .hits_o (bank_hits[b]),
      .rank_o (bank_rank[b]),
      .idx_o  (bank_idx[b])
    );

    // R3: switched-off bank stays silent.
    a_r3_inactive_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_cfg[b].active |-> bank_hits[b] == 8'd0)
      else $error("a_r3_inactive_silent bank %0d", b);

    // R6: 32-bit bank with disagreeing mode bits stays silent.
    a_r6_mismatch_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_cfg[b].scale[1] && (bank_cfg[b].mode_lo != bank_cfg[b].mode_hi))
        |-> bank_hits[b] == 8'd0)
      else $error("a_r6_mismatch_silent bank %0d", b);
  end

  cfb_priority_pick #(.NB(NUM_BANKS), .IDX_W(IDX_W)) u_pick (
    .hits_i(bank_hits),
    .rank_i(bank_rank),
    .idx_i (bank_idx),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_valid  <= 1'b0;
      match_accept <= 1'b0;
      match_index  <= '0;
    end else begin
      match_valid  <= id_valid;
      match_accept <= id_valid && pick_any;
      match_index  <= (id_valid && pick_any) ? pick_idx : '0;
    end
  end

  // R13: result appears exactly one cycle after the strobe.
  a_r13_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> match_valid)
    else $error("a_r13_valid_follows");

  a_r13_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> !match_valid && !match_accept)
    else $error("a_r13_no_spurious");

  // R13: reject or idle carries a zero number.
  a_r13_zero_index: assert property (@(posedge clk) disable iff (!rst_n)
    !match_accept |-> match_index == '0)
    else $error("a_r13_zero_index");

  // R12: a reported number lies inside the numbered range.
  a_r12_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && pick_any) |-> CNT_W'(pick_idx) < total_cnt)
    else $error("a_r12_in_range");

endmodule

// File: tb/can_filter_bank_array_tb.sv
`timescale 1ns/1ps
module can_filter_bank_array_tb;

  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic        id_valid;
  logic [31:0] id_in;
  logic        match_valid;
  logic        match_accept;
  logic [4:0]  match_index;

  always #2.5 clk = ~clk;

  can_filter_bank_array #(.NUM_BANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .id_valid(id_valid), .id_in(id_in),
    .match_valid(match_valid), .match_accept(match_accept),
    .match_index(match_index)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  string cur_req = "R1";

  // Behavioural model state.
  logic [7:0] m_byte [NB][8];
  bit         m_act  [NB];
  int         m_scale[NB];
  bit         m_lo   [NB];
  bit         m_hi   [NB];
  bit         e_valid, e_acc;
  int         e_idx;

  task automatic chk(string tag, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  function automatic void model_pick(input logic [31:0] id, output bit acc,
                                     output int idx);
    int num, best, nf, w, rpf, base, half, cov;
    logic [31:0] first, second, key;
    bit lst;
    num = 0; best = -1; acc = 0; idx = 0;
    for (int b = 0; b < NB; b++) begin
      nf  = (m_scale[b] == 0) ? 4 : (m_scale[b] == 1) ? 2 : 1;
      w   = 32 / nf;
      rpf = 8 / nf;
      cov = (nf == 1) ? 2 : (nf == 2) ? 1 : 0;
      for (int f = 0; f < nf; f++) begin
        base = f * rpf; half = rpf / 2;
        first = 0; second = 0;
        for (int k = 0; k < half; k++) begin
          first  = first  | (32'(m_byte[b][base + k]) << (8 * k));
          second = second | (32'(m_byte[b][base + half + k]) << (8 * k));
        end
        key = id >> (32 - w);
        if (nf == 1 && m_lo[b] != m_hi[b]) begin
          num++;
          continue;
        end
        lst = (nf == 1) ? m_lo[b] : ((f < nf / 2) ? m_lo[b] : m_hi[b]);
        if (lst) begin
          if (m_act[b] && key == first && (4 + cov) > best) begin best = 4 + cov; idx = num; end
          num++;
          if (m_act[b] && key == second && (4 + cov) > best) begin best = 4 + cov; idx = num; end
          num++;
        end else begin
          if (m_act[b] && ((key ^ first) & second) == 0 && cov > best) begin best = cov; idx = num; end
          num++;
        end
      end
    end
    acc = (best >= 0);
    if (!acc) idx = 0;
  endfunction

  // One clock: predict from pre-edge state, apply the write, compare after edge.
  task automatic tick();
    bit a; int i;
    e_valid = id_valid;
    if (id_valid) begin
      model_pick(id_in, a, i);
      e_acc = a; e_idx = i;
    end else begin
      e_acc = 0; e_idx = 0;
    end
    if (cfg_we) begin
      if (cfg_addr[5]) begin
        m_act[cfg_addr[4:3]]   = cfg_wdata[0];
        m_scale[cfg_addr[4:3]] = (cfg_wdata[2:1] >= 2) ? 2 : int'(cfg_wdata[2:1]);
        m_lo[cfg_addr[4:3]]    = cfg_wdata[3];
        m_hi[cfg_addr[4:3]]    = cfg_wdata[4];
      end else if (!m_act[cfg_addr[4:3]]) begin
        m_byte[cfg_addr[4:3]][cfg_addr[2:0]] = cfg_wdata;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk({cur_req, " R13 valid"}, int'(match_valid), int'(e_valid));
    chk({cur_req, " accept"}, int'(match_accept), int'(e_acc));
    chk({cur_req, " index"}, int'(match_index), e_idx);
  endtask

  task automatic wr(int addr, int data);
    cfg_we = 1; cfg_addr = 6'(addr); cfg_wdata = 8'(data);
    tick();
    cfg_we = 0;
  endtask

  task automatic ctl(int b, int act, int sc, int lo, int hi);
    wr(32 + b * 8, act | (sc << 1) | (lo << 3) | (hi << 4));
  endtask

  task automatic set32(int b, logic [31:0] w0, logic [31:0] w1);
    for (int k = 0; k < 4; k++) wr(b * 8 + k, int'(w0[8*k +: 8]));
    for (int k = 0; k < 4; k++) wr(b * 8 + 4 + k, int'(w1[8*k +: 8]));
  endtask

  task automatic probe(logic [31:0] id, int acc, int idx, string tag);
    id_valid = 1; id_in = id;
    tick();
    id_valid = 0;
    chk({tag, " accept"}, int'(match_accept), acc);
    chk({tag, " index"}, int'(match_index), idx);
  endtask

  function automatic logic [7:0] rbyte();
    case ($urandom % 4)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h3C;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_act[b] = 0; m_scale[b] = 0; m_lo[b] = 0; m_hi[b] = 0;
      for (int k = 0; k < 8; k++) m_byte[b][k] = 8'h00;
    end
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; id_valid = 0; id_in = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(match_valid), 0);
    chk("R1 reset accept", int'(match_accept), 0);
    chk("R1 reset index", int'(match_index), 0);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    probe(32'h0000_0000, 0, 0, "R1 zero id after reset");
    tick();
    chk("R13 idle valid", int'(match_valid), 0);

    cur_req = "R8";
    set32(0, 32'h1234_5678, 32'hCAFE_0001);
    ctl(0, 1, 2, 1, 1);
    probe(32'h1234_5678, 1, 0, "R8 list first word");
    probe(32'hCAFE_0001, 1, 1, "R8 list second word");
    probe(32'h1234_5679, 0, 0, "R8 near miss");

    cur_req = "R7";
    set32(1, 32'hAB00_0000, 32'hFF00_0000);
    ctl(1, 1, 2, 0, 0);
    probe(32'hAB12_3456, 1, 2, "R7 mask hit R12 numbering");
    probe(32'hAC00_0000, 0, 0, "R7 mask miss");

    cur_req = "R9";
    ctl(0, 0, 2, 1, 1);
    set32(0, 32'h0, 32'h0);
    ctl(0, 1, 2, 0, 0);
    ctl(1, 0, 2, 0, 0);
    set32(1, 32'h5555_AAAA, 32'h0F0F_0F0F);
    ctl(1, 1, 2, 1, 1);
    probe(32'h5555_AAAA, 1, 1, "R9 list beats lower mask");
    probe(32'h0F0F_0F0F, 1, 2, "R9 list second");
    probe(32'h0000_0007, 1, 0, "R7 catch-all mask");

    cur_req = "R10";
    ctl(0, 0, 2, 0, 0);
    wr(16, 8'h11); wr(17, 8'h11); wr(18, 8'hFF); wr(19, 8'hFF);
    wr(20, 8'h22); wr(21, 8'h22); wr(22, 8'hFF); wr(23, 8'hFF);
    ctl(2, 1, 1, 0, 0);
    set32(3, 32'h1111_0000, 32'hFFFF_0000);
    ctl(3, 1, 2, 0, 0);
    probe(32'h1111_ABCD, 1, 5, "R10 32-bit beats lower 16-bit");
    probe(32'h2222_0000, 1, 4, "R4 16-bit second filter");
    probe(32'h0000_0007, 0, 0, "R3 inactive catch-all");

    cur_req = "R11";
    ctl(2, 0, 1, 0, 0);
    wr(20, 8'h11); wr(21, 8'h11);
    ctl(2, 1, 1, 0, 0);
    ctl(3, 0, 2, 0, 0);
    probe(32'h1111_0000, 1, 3, "R11 tie lowest number");

    cur_req = "R6";
    ctl(3, 1, 2, 1, 0);
    probe(32'h1111_0000, 1, 3, "R6 mismatched bank silent");

    cur_req = "R2";
    wr(16, 8'h99);
    probe(32'h1111_0000, 1, 3, "R2 locked write ignored");
    probe(32'h1199_0000, 0, 0, "R2 locked byte unchanged");
    ctl(2, 0, 1, 0, 0);
    wr(16, 8'h99);
    ctl(2, 1, 1, 0, 0);
    probe(32'h1199_0000, 1, 3, "R2 unlocked write applied");
    probe(32'h1111_0000, 1, 4, "R2 other filter");

    cur_req = "R5";
    ctl(0, 0, 0, 0, 0);
    wr(0, 8'h41); wr(1, 8'h42); wr(2, 8'h43); wr(3, 8'h44);
    wr(4, 8'h50); wr(5, 8'hF0); wr(6, 8'h60); wr(7, 8'hFF);
    ctl(0, 1, 0, 1, 0);
    probe(32'h4400_0000, 1, 3, "R5 8-bit low list");
    probe(32'h5A00_0000, 1, 4, "R5 8-bit high mask");
    probe(32'h6000_0000, 1, 5, "R5 8-bit exact mask");
    probe(32'h6100_0000, 0, 0, "R5 8-bit miss");
    probe(32'h0F0F_0F0F, 1, 7, "R12 shifted numbering");
    ctl(2, 0, 1, 1, 0);
    ctl(2, 1, 1, 1, 0);
    probe(32'hFFFF_0000, 1, 9, "R5 16-bit low list second word");
    probe(32'h1111_2222, 1, 10, "R5 16-bit high mask");

    cur_req = "R4 random";
    for (int op = 0; op < 2500; op++) begin
      int b, sel, k;
      b = $urandom % NB;
      sel = $urandom % 10;
      if (sel == 0) begin
        ctl(b, 0, m_scale[b], m_lo[b], m_hi[b]);
        for (int r = 0; r < 8; r++) if ($urandom % 2) wr(b * 8 + r, rbyte());
        ctl(b, ($urandom % 5) != 0, $urandom % 4, $urandom % 2, $urandom % 2);
      end else if (sel == 1) begin
        wr(b * 8 + ($urandom % 8), rbyte());
      end else begin
        k = $urandom % 7;
        id_valid = 1;
        case ($urandom % 3)
          0: id_in = $urandom;
          1: id_in = {m_byte[b][k + 1], m_byte[b][k], 16'($urandom)};
          default: id_in = {m_byte[b][k], 24'($urandom)};
        endcase
        tick();
        id_valid = 0;
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule